// File: doc/BRIEF.md
# Writeback Queue Scoreboard

This block holds the register writebacks that a simple 32-bit in-order core has issued from execute but not yet retired. Entries leave in the order they arrived. Each entry has one of four kinds: an ALU result (destination and 32-bit value), a load (destination only, with the value still to come from data memory), a store, or a host/coprocessor write. Store and host entries name no register.

The same storage also serves as the hazard detector. Decode gives an operation class and up to three register indices. The block picks which indices must be probed for that class and raises `stall` when any of them names a destination still waiting in the queue. Two further search ports, independent of the hazard logic, let neighbouring logic probe the queue directly. All searches are combinational and see only the queue contents held at the start of the cycle.

On the writeback side, a request retires the head entry. ALU entries write their value to the register file. Load entries wait for a data-memory response, consume it and write its data. Store entries consume a response and write nothing. Host entries do nothing.

Top module: `wbq_scoreboard`

## Requirements
- R1: After reset the queue is empty: `head_valid`=0, `enq_ready`=1, `stall`=0 and both search hits are 0.
- R2: The queue holds DEPTH entries (4 by default). When full, `enq_ready` is 0 and an `enq_valid` pulse is dropped, leaving contents and order unchanged.
- R3: Entries retire in arrival order. The head outputs show the oldest entry (kind codes 0=ALU, 1=load, 2=store, 3=host) and hold steady until it is retired.
- R4: A search hits only on a held ALU (kind 0) or load (kind 1) entry whose destination equals the probe. Store and host entries never hit, whatever their destination field holds. A probe of register 0 never hits.
- R5: The two search ports are evaluated in the same cycle and independently of each other.
- R6: A search sees exactly the entries held at the start of the cycle. An entry enqueued in the same cycle is not seen. An entry retired in the same cycle is still seen.
- R7: Class 1 (one source) stalls when `op_ra` is pending. Class 2 (two-source ALU or register-compare branch) stalls when `op_ra` or `op_rb` is pending. Class 4 (load) stalls only when the base `op_ra` is pending.
- R8: Class 5 (store) stalls when either the base register `op_ra` or the data register `op_rb` is pending.
- R9: Class 3 (variable-amount shift) stalls when the value register `op_ra` or the shift-amount register `op_rb` is pending.
- R10: Class 0 (absolute jumps and coprocessor reads) and every class code above 6 never stall. Class 6 (load-upper-immediate) stalls only when its own destination `op_rd` is pending.
- R11: With `wb_req` high, an ALU head retires in that cycle. It drives `rf_we` with its destination and value and does not pop memory.
- R12: A load head retires only while `mem_resp_valid` is high. It then asserts `mem_pop` and writes `mem_resp_data` to its destination.
- R13: A store head retires only with a memory response, which it pops without a register write. A host head retires with neither a pop nor a write.
- R14: Searches and retire order stay correct when the live entries wrap around the end of the storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | Push a new entry |
| enq_kind | input | 2 | Kind of the new entry |
| enq_dest | input | 5 | Destination register of the new entry |
| enq_data | input | 32 | ALU result of the new entry |
| enq_ready | output | 1 | Queue has a free slot |
| head_valid | output | 1 | Queue holds at least one entry |
| head_kind | output | 2 | Kind of the oldest entry |
| head_dest | output | 5 | Destination of the oldest entry |
| head_data | output | 32 | Value of the oldest entry |
| wb_req | input | 1 | Writeback stage asks to retire the head |
| wb_done | output | 1 | Head retires in this cycle |
| mem_resp_valid | input | 1 | A data-memory response is available |
| mem_resp_data | input | 32 | Data of that response |
| mem_pop | output | 1 | Consume the memory response |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 5 | Register file write index |
| rf_wdata | output | 32 | Register file write data |
| srch_a_idx | input | 5 | Probe index, search port A |
| srch_a_hit | output | 1 | Port A found a pending write |
| srch_b_idx | input | 5 | Probe index, search port B |
| srch_b_hit | output | 1 | Port B found a pending write |
| op_class | input | 4 | Operation class of the decoded instruction |
| op_ra | input | 5 | First source register |
| op_rb | input | 5 | Second source register |
| op_rd | input | 5 | Destination register |
| stall | output | 1 | Instruction must wait |

## Verification
A queue filled with one entry of each kind is probed with store and host destination fields, with live ALU and load destinations, and with register 0. This shows whether the match is gated by kind, by validity and by the zero index. Each operation class is tried with the pending register placed in `op_ra`, `op_rb` or `op_rd` in turn, so a wrong selection of operand for a class is caught. Same-cycle push and retire patterns check the start-of-cycle visibility rule. A second fill after the pointers have wrapped checks that search and order do not depend on slot position. Withholding the memory response while a load is at the head separates entries that retire at once from those that must wait.

// File: rtl/wbq_pkg.sv
package wbq_pkg;
    localparam int unsigned XLEN   = 32;
    localparam int unsigned RIDX_W = 5;
    localparam int unsigned CLS_W  = 4;

    typedef enum logic [1:0] {
        WBK_ALU   = 2'd0,
        WBK_LOAD  = 2'd1,
        WBK_STORE = 2'd2,
        WBK_HOST  = 2'd3
    } wb_kind_e;

    typedef struct packed {
        wb_kind_e            kind;
        logic [RIDX_W-1:0]   dest;
        logic [XLEN-1:0]     data;
    } wb_entry_t;

    typedef enum logic [CLS_W-1:0] {
        OPC_NONE    = 4'd0,
        OPC_ONE_SRC = 4'd1,
        OPC_TWO_SRC = 4'd2,
        OPC_VSHIFT  = 4'd3,
        OPC_LOAD    = 4'd4,
        OPC_STORE   = 4'd5,
        OPC_LUI     = 4'd6
    } op_class_e;
endpackage

// File: rtl/wbq_search.sv
module wbq_search
    import wbq_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  wb_entry_t [DEPTH-1:0] entries,
    input  logic [DEPTH-1:0]      valid,
    input  logic [RIDX_W-1:0]     probe,
    output logic                  hit
);
    // Only entries that name a register can match; r0 is never pending.
    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (valid[i] && (entries[i].kind == WBK_ALU || entries[i].kind == WBK_LOAD)
                && entries[i].dest == probe) begin
                hit = 1'b1;
            end
        end
        if (probe == '0) begin
            hit = 1'b0;
        end
    end
endmodule

// File: rtl/wbq_hazard_sel.sv
module wbq_hazard_sel
    import wbq_pkg::*;
(
    input  logic [CLS_W-1:0]  op_class,
    input  logic [RIDX_W-1:0] op_ra,
    input  logic [RIDX_W-1:0] op_rb,
    input  logic [RIDX_W-1:0] op_rd,
    output logic [RIDX_W-1:0] idx0,
    output logic [RIDX_W-1:0] idx1,
    output logic              use0,
    output logic              use1
);
    // Chooses which register indices the two hazard probes look up.
    always_comb begin
        idx0 = op_ra;
        idx1 = op_rb;
        use0 = 1'b0;
        use1 = 1'b0;
        case (op_class_e'(op_class))
            OPC_ONE_SRC, OPC_LOAD: begin
                use0 = 1'b1;
            end
            OPC_TWO_SRC, OPC_VSHIFT, OPC_STORE: begin
                use0 = 1'b1;
                use1 = 1'b1;
            end
            OPC_LUI: begin
                idx0 = op_rd;
                use0 = 1'b1;
            end
            default: begin
                use0 = 1'b0;
                use1 = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/wbq_scoreboard.sv
module wbq_scoreboard
    import wbq_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enq_valid,
    input  logic [1:0]        enq_kind,
    input  logic [4:0]        enq_dest,
    input  logic [31:0]       enq_data,
    output logic              enq_ready,
    output logic              head_valid,
    output logic [1:0]        head_kind,
    output logic [4:0]        head_dest,
    output logic [31:0]       head_data,
    input  logic              wb_req,
    output logic              wb_done,
    input  logic              mem_resp_valid,
    input  logic [31:0]       mem_resp_data,
    output logic              mem_pop,
    output logic              rf_we,
    output logic [4:0]        rf_waddr,
    output logic [31:0]       rf_wdata,
    input  logic [4:0]        srch_a_idx,
    output logic              srch_a_hit,
    input  logic [4:0]        srch_b_idx,
    output logic              srch_b_hit,
    input  logic [3:0]        op_class,
    input  logic [4:0]        op_ra,
    input  logic [4:0]        op_rb,
    input  logic [4:0]        op_rd,
    output logic              stall
);
    localparam int unsigned PTR_W      = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W      = $clog2(DEPTH + 1);
    localparam int unsigned NUM_PROBES = 4;   // two hazard probes, two external ports

    typedef struct packed {
        wb_entry_t [DEPTH-1:0] slot;
        logic [DEPTH-1:0]      valid;
        logic [PTR_W-1:0]      head;
        logic [PTR_W-1:0]      tail;
        logic [CNT_W-1:0]      count;
    } state_t;

    state_t st_q, st_d;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // ---------------- hazard operand selection ----------------
    logic [RIDX_W-1:0] hz_idx0, hz_idx1;
    logic              hz_use0, hz_use1;

    wbq_hazard_sel u_sel (
        .op_class (op_class),
        .op_ra    (op_ra),
        .op_rb    (op_rb),
        .op_rd    (op_rd),
        .idx0     (hz_idx0),
        .idx1     (hz_idx1),
        .use0     (hz_use0),
        .use1     (hz_use1)
    );

    // ---------------- associative searches on registered state ----------------
    logic [RIDX_W-1:0]     probe_idx [NUM_PROBES];
    logic [NUM_PROBES-1:0] probe_hit;

    always_comb begin
        probe_idx[0] = hz_idx0;
        probe_idx[1] = hz_idx1;
        probe_idx[2] = srch_a_idx;
        probe_idx[3] = srch_b_idx;
    end

    for (genvar p = 0; p < NUM_PROBES; p++) begin : g_probe
        wbq_search #(.DEPTH(DEPTH)) u_search (
            .entries (st_q.slot),
            .valid   (st_q.valid),
            .probe   (probe_idx[p]),
            .hit     (probe_hit[p])
        );
    end

    assign stall      = (hz_use0 && probe_hit[0]) || (hz_use1 && probe_hit[1]);
    assign srch_a_hit = probe_hit[2];
    assign srch_b_hit = probe_hit[3];

    // ---------------- queue control and writeback ----------------
    wb_entry_t head_e;
    wb_entry_t new_e;
    logic      enq_fire;
    logic      head_mem;

    always_comb begin
        head_e     = st_q.slot[st_q.head];
        head_valid = (st_q.count != '0);
        head_kind  = head_e.kind;
        head_dest  = head_e.dest;
        head_data  = head_e.data;

        enq_ready  = (st_q.count != CNT_W'(DEPTH));
        enq_fire   = enq_valid && enq_ready;
        new_e.kind = wb_kind_e'(enq_kind);
        new_e.dest = enq_dest;
        new_e.data = enq_data;

        head_mem   = (head_e.kind == WBK_LOAD) || (head_e.kind == WBK_STORE);
        wb_done    = wb_req && head_valid && (!head_mem || mem_resp_valid);
        mem_pop    = wb_done && head_mem;
        rf_we      = wb_done && ((head_e.kind == WBK_ALU) || (head_e.kind == WBK_LOAD));
        rf_waddr   = head_e.dest;
        rf_wdata   = (head_e.kind == WBK_LOAD) ? mem_resp_data : head_e.data;

        st_d = st_q;
        if (enq_fire) begin
            st_d.slot[st_q.tail]  = new_e;
            st_d.valid[st_q.tail] = 1'b1;
            st_d.tail             = ptr_inc(st_q.tail);
        end
        if (wb_done) begin
            st_d.valid[st_q.head] = 1'b0;
            st_d.head             = ptr_inc(st_q.head);
        end
        case ({enq_fire, wb_done})
            2'b10:   st_d.count = st_q.count + 1'b1;
            2'b01:   st_d.count = st_q.count - 1'b1;
            default: st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/wbq_scoreboard_chk.sv
module wbq_scoreboard_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        enq_ready,
    input logic        head_valid,
    input logic [1:0]  head_kind,
    input logic [4:0]  head_dest,
    input logic [31:0] head_data,
    input logic        wb_req,
    input logic        wb_done,
    input logic        mem_resp_valid,
    input logic        mem_pop,
    input logic        rf_we,
    input logic [4:0]  srch_a_idx,
    input logic        srch_a_hit,
    input logic [4:0]  srch_b_idx,
    input logic        srch_b_hit,
    input logic [3:0]  op_class,
    input logic        stall
);
    p_empty_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !head_valid |-> enq_ready);

    p_empty_nohit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !head_valid |-> (!srch_a_hit && !srch_b_hit && !stall));

    p_zero_probe_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (srch_a_idx == 5'd0) |-> !srch_a_hit);

    p_zero_probe_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (srch_b_idx == 5'd0) |-> !srch_b_hit);

    p_none_class_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class == 4'd0) |-> !stall);

    p_head_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (head_valid && !wb_done) |=> (head_valid && $stable(head_kind)
                                      && $stable(head_dest) && $stable(head_data)));

    p_pop_needs_resp_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_pop |-> (mem_resp_valid && wb_done));

    p_load_waits_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (head_valid && head_kind == 2'd1 && wb_req && !mem_resp_valid) |-> !wb_done);

    p_store_pop_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_done && head_kind == 2'd2) |-> (mem_pop && !rf_we));

    p_host_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_done && head_kind == 2'd3) |-> (!mem_pop && !rf_we));
endmodule

bind wbq_scoreboard wbq_scoreboard_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .enq_ready      (enq_ready),
    .head_valid     (head_valid),
    .head_kind      (head_kind),
    .head_dest      (head_dest),
    .head_data      (head_data),
    .wb_req         (wb_req),
    .wb_done        (wb_done),
    .mem_resp_valid (mem_resp_valid),
    .mem_pop        (mem_pop),
    .rf_we          (rf_we),
    .srch_a_idx     (srch_a_idx),
    .srch_a_hit     (srch_a_hit),
    .srch_b_idx     (srch_b_idx),
    .srch_b_hit     (srch_b_hit),
    .op_class       (op_class),
    .stall          (stall)
);

// File: tb/wbq_scoreboard_bench.sv
module wbq_scoreboard_bench;
    timeunit 1ns;
    timeprecision 100ps;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n;
    logic        enq_valid;
    logic [1:0]  enq_kind;
    logic [4:0]  enq_dest;
    logic [31:0] enq_data;
    logic        enq_ready;
    logic        head_valid;
    logic [1:0]  head_kind;
    logic [4:0]  head_dest;
    logic [31:0] head_data;
    logic        wb_req;
    logic        wb_done;
    logic        mem_resp_valid;
    logic [31:0] mem_resp_data;
    logic        mem_pop;
    logic        rf_we;
    logic [4:0]  rf_waddr;
    logic [31:0] rf_wdata;
    logic [4:0]  srch_a_idx;
    logic        srch_a_hit;
    logic [4:0]  srch_b_idx;
    logic        srch_b_hit;
    logic [3:0]  op_class;
    logic [4:0]  op_ra;
    logic [4:0]  op_rb;
    logic [4:0]  op_rd;
    logic        stall;

    wbq_scoreboard u_wbq_scoreboard (
        .clk(clk), .rst_n(rst_n),
        .enq_valid(enq_valid), .enq_kind(enq_kind), .enq_dest(enq_dest), .enq_data(enq_data),
        .enq_ready(enq_ready),
        .head_valid(head_valid), .head_kind(head_kind), .head_dest(head_dest), .head_data(head_data),
        .wb_req(wb_req), .wb_done(wb_done),
        .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data), .mem_pop(mem_pop),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .srch_a_idx(srch_a_idx), .srch_a_hit(srch_a_hit),
        .srch_b_idx(srch_b_idx), .srch_b_hit(srch_b_hit),
        .op_class(op_class), .op_ra(op_ra), .op_rb(op_rb), .op_rd(op_rd),
        .stall(stall)
    );

    typedef struct {
        bit          we;
        bit          pop;
        logic [4:0]  addr;
        logic [31:0] data;
        string       req;
    } exp_t;

    exp_t        expq[$];
    logic [31:0] memq[$];
    bit          mem_en;
    int          n_checks;
    int          n_fail;
    bit          finished;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Scoreboard monitor: refresh memory response, then compare each retirement.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #0.5;
            mem_resp_valid = mem_en && (memq.size() > 0);
            mem_resp_data  = (memq.size() > 0) ? memq[0] : 32'h0;
            #0.5;
            if (rst_n && wb_done) begin
                if (expq.size() == 0) begin
                    chk("R3", "unexpected retirement", 32'(wb_done), 32'h0);
                end else begin
                    e = expq.pop_front();
                    chk(e.req, "rf_we", 32'(rf_we), 32'(e.we));
                    chk(e.req, "mem_pop", 32'(mem_pop), 32'(e.pop));
                    if (e.we) begin
                        chk(e.req, "rf_waddr", 32'(rf_waddr), 32'(e.addr));
                        chk(e.req, "rf_wdata", rf_wdata, e.data);
                    end
                end
                if (mem_pop && memq.size() > 0) memq.pop_front();
            end
        end
    end

    task automatic start_cycle();
        @(negedge clk);
        enq_valid = 1'b0;
        wb_req    = 1'b0;
    endtask

    // Driver: push an entry and record what its retirement must look like.
    task automatic push(input logic [1:0] kind, input logic [4:0] dest,
                        input logic [31:0] data, input logic [31:0] memval);
        exp_t e;
        start_cycle();
        enq_valid = 1'b1;
        enq_kind  = kind;
        enq_dest  = dest;
        enq_data  = data;
        e.we = 1'b0; e.pop = 1'b0; e.addr = dest; e.data = data;
        case (kind)
            2'd0: begin e.we = 1'b1; e.req = "R11"; end
            2'd1: begin e.we = 1'b1; e.pop = 1'b1; e.data = memval; e.req = "R12"; memq.push_back(memval); end
            2'd2: begin e.pop = 1'b1; e.req = "R13"; memq.push_back(memval); end
            default: begin e.req = "R13"; end
        endcase
        expq.push_back(e);
    endtask

    task automatic probe(input logic [4:0] a, input logic [4:0] b,
                         input bit ea, input bit eb, input string req);
        start_cycle();
        srch_a_idx = a;
        srch_b_idx = b;
        #1.5;
        chk(req, "srch_a_hit", 32'(srch_a_hit), 32'(ea));
        chk(req, "srch_b_hit", 32'(srch_b_hit), 32'(eb));
    endtask

    task automatic hazard(input logic [3:0] cls, input logic [4:0] ra, input logic [4:0] rb,
                          input logic [4:0] rd, input bit exp, input string req);
        start_cycle();
        op_class = cls; op_ra = ra; op_rb = rb; op_rd = rd;
        #1.5;
        chk(req, "stall", 32'(stall), 32'(exp));
        op_class = 4'd0;
    endtask

    task automatic retire();
        start_cycle();
        wb_req = 1'b1;
    endtask

    initial begin
        #100000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; enq_valid = 1'b0; enq_kind = 2'd0; enq_dest = 5'd0; enq_data = 32'h0;
        wb_req = 1'b0; mem_resp_valid = 1'b0; mem_resp_data = 32'h0;
        srch_a_idx = 5'd0; srch_b_idx = 5'd0; op_class = 4'd0; op_ra = 5'd0; op_rb = 5'd0; op_rd = 5'd0;
        mem_en = 1'b1; n_checks = 0; n_fail = 0; finished = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        start_cycle();
        #1.5;
        chk("R1", "head_valid", 32'(head_valid), 32'h0);
        chk("R1", "enq_ready", 32'(enq_ready), 32'h1);
        chk("R1", "stall", 32'(stall), 32'h0);
        chk("R1", "srch hits", {30'h0, srch_a_hit, srch_b_hit}, 32'h0);

        // Fill with one of each kind; store/host carry decoy destinations
        push(2'd0, 5'd5, 32'h1111_1111, 32'h0);
        push(2'd1, 5'd6, 32'h0, 32'hCAFE_0006);
        push(2'd2, 5'd9, 32'h0, 32'h0);
        push(2'd3, 5'd10, 32'h0, 32'h0);

        // R2: full queue refuses a push
        start_cycle();
        #1.5;
        chk("R2", "enq_ready when full", 32'(enq_ready), 32'h0);
        enq_valid = 1'b1; enq_kind = 2'd0; enq_dest = 5'd12; enq_data = 32'hDEAD;
        probe(5'd12, 5'd12, 1'b0, 1'b0, "R2");

        // R3: head is the oldest entry
        start_cycle();
        #1.5;
        chk("R3", "head_kind", 32'(head_kind), 32'd0);
        chk("R3", "head_dest", 32'(head_dest), 32'd5);
        chk("R3", "head_data", head_data, 32'h1111_1111);

        // R4/R5: kinds gate the match; two ports at once
        probe(5'd5, 5'd6, 1'b1, 1'b1, "R5");
        probe(5'd9, 5'd10, 1'b0, 1'b0, "R4");
        probe(5'd0, 5'd6, 1'b0, 1'b1, "R4");

        // R7..R10: operand selection per class
        hazard(4'd2, 5'd1, 5'd6, 5'd0, 1'b1, "R7");
        hazard(4'd2, 5'd1, 5'd2, 5'd0, 1'b0, "R7");
        hazard(4'd1, 5'd2, 5'd5, 5'd0, 1'b0, "R7");
        hazard(4'd1, 5'd5, 5'd2, 5'd0, 1'b1, "R7");
        hazard(4'd4, 5'd5, 5'd1, 5'd0, 1'b1, "R7");
        hazard(4'd4, 5'd1, 5'd5, 5'd0, 1'b0, "R7");
        hazard(4'd5, 5'd1, 5'd6, 5'd0, 1'b1, "R8");
        hazard(4'd5, 5'd6, 5'd1, 5'd0, 1'b1, "R8");
        hazard(4'd5, 5'd1, 5'd2, 5'd6, 1'b0, "R8");
        hazard(4'd3, 5'd2, 5'd5, 5'd0, 1'b1, "R9");
        hazard(4'd3, 5'd6, 5'd2, 5'd0, 1'b1, "R9");
        hazard(4'd0, 5'd5, 5'd6, 5'd5, 1'b0, "R10");
        hazard(4'd9, 5'd5, 5'd6, 5'd5, 1'b0, "R10");
        hazard(4'd6, 5'd1, 5'd2, 5'd5, 1'b1, "R10");
        hazard(4'd6, 5'd5, 5'd6, 5'd3, 1'b0, "R10");

        // R11: ALU retires at once; R12: load waits for memory
        mem_en = 1'b0;
        retire();
        retire();
        #1.5;
        chk("R12", "load waits wb_done", 32'(wb_done), 32'h0);
        chk("R12", "load still head", 32'(head_kind), 32'd1);
        mem_en = 1'b1;
        retire();
        retire();
        retire();
        start_cycle();
        #1.5;
        chk("R13", "empty after drain", 32'(head_valid), 32'h0);

        // R6: same-cycle push invisible, same-cycle retire still visible
        push(2'd0, 5'd7, 32'h0000_0077, 32'h0);
        srch_a_idx = 5'd7; op_class = 4'd1; op_ra = 5'd7;
        #1.5;
        chk("R6", "push not yet seen", 32'(srch_a_hit), 32'h0);
        chk("R6", "no stall on new push", 32'(stall), 32'h0);
        start_cycle();
        op_class = 4'd0;
        #1.5;
        chk("R6", "entry seen next cycle", 32'(srch_a_hit), 32'h1);
        retire();
        #1.5;
        chk("R6", "retiring entry seen", 32'(srch_a_hit), 32'h1);
        chk("R6", "retire fires", 32'(wb_done), 32'h1);
        start_cycle();
        #1.5;
        chk("R6", "gone after retire", 32'(srch_a_hit), 32'h0);

        // R14: live entries wrap past the end of storage
        push(2'd0, 5'd20, 32'h2020_2020, 32'h0);
        push(2'd1, 5'd21, 32'h0, 32'hBEEF_0021);
        push(2'd0, 5'd22, 32'h2222_2222, 32'h0);
        push(2'd0, 5'd23, 32'h2323_2323, 32'h0);
        retire();
        retire();
        push(2'd1, 5'd24, 32'h0, 32'hBEEF_0024);
        push(2'd0, 5'd25, 32'h2525_2525, 32'h0);
        probe(5'd22, 5'd23, 1'b1, 1'b1, "R14");
        probe(5'd24, 5'd25, 1'b1, 1'b1, "R14");
        probe(5'd20, 5'd21, 1'b0, 1'b0, "R14");
        start_cycle();
        #1.5;
        chk("R14", "full after wrap", 32'(enq_ready), 32'h0);
        chk("R14", "head after wrap", 32'(head_dest), 32'd22);
        repeat (4) retire();
        start_cycle();
        start_cycle();
        #1.5;
        chk("R14", "empty after wrap drain", 32'(head_valid), 32'h0);
        chk("R11", "all retirements seen", 32'(expq.size()), 32'h0);

        finished = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule